// File: doc/BRIEF.md
# Quad-wire serial flash fast-read controller

This block is the host side of a serial flash link that runs with all four data wires active in both directions. On a read request it lowers chip select and clocks out the fast-read opcode 0x0B and then a 24-bit start address, four bits per serial clock. It then runs a programmable number of dummy clocks and releases the data wires, so that the flash can return data on them. Each byte comes back over two serial clocks and is handed to the requester on a single-cycle strobe.

A two-bit read-parameter register selects how many dummy clocks are inserted. The host loads it through a write port, in the same way that the flash itself is given the value by its own set-read-parameters command. The serial clock is derived from the system clock by an even division ratio. The requester gives a start address and a byte count, waits for the end pulse, and can then issue the next read.

Top module: `qfr_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no request made: `cs_n` is 1, `sclk` is 0, `io_oe` is 0, `req_ready` is 1, and `rd_valid` and `done` are 0.
- R2: The first two serial clocks of a read carry the opcode 0x0B on `io_out` with `io_oe` = 4'hF: high nibble 0x0 on clock 0, then low nibble 0xB. `io_out` never changes in a cycle in which `sclk` is high.
- R3: Serial clocks 2 to 7 carry the 24-bit address, most significant nibble first, with `io_out[3]` holding bit 23, 19, 15 and so on and `io_out[0]` holding bit 20, 16, 12 and so on.
- R4: The number of dummy clocks after the address is 4 when `cfg_field` is 2'b00 or 2'b01, 6 when it is 2'b10 and 8 when it is 2'b11. The value stored by `cfg_we` at the moment a request is accepted applies to that read. A write made during a read takes effect only from the next read.
- R5: `io_oe` is 4'hF from the first opcode clock through the last dummy clock. It is released to 4'h0 at the falling edge that ends the last dummy clock and stays 0 for every data clock and while `cs_n` is high. It is always either 4'h0 or 4'hF.
- R6: A read returns `req_len`+1 bytes in address order. Each byte is sampled from `io_in` on two rising `sclk` edges, high nibble first, and is presented on `rd_data` with a `rd_valid` pulse one system cycle long.
- R7: `cs_n` falls before the first rising `sclk` edge and rises only after the last falling edge. `sclk` is 0 whenever `cs_n` is 1. A read has exactly 8 + dummy + 2·(`req_len`+1) rising `sclk` edges.
- R8: `done` is a single-cycle pulse in the cycle after `cs_n` returns to 1, and `req_ready` is 1 in that same cycle.
- R9: The serial clock is high for DIV/2 system cycles and low for DIV/2 system cycles, from the fall of `cs_n` onwards.
- R10: A request is accepted only in a cycle with `req_ready` = 1. `req_valid` asserted while a read is in progress has no effect on that read's address, byte count or end pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the read-parameter field |
| cfg_field | input | 2 | New dummy-count field value |
| req_valid | input | 1 | Read request |
| req_ready | output | 1 | Controller idle; request is accepted |
| req_addr | input | 24 | Start byte address |
| req_len | input | CNT_W | Number of bytes to read minus one |
| rd_valid | output | 1 | One-cycle strobe with each returned byte |
| rd_data | output | 8 | Returned byte |
| done | output | 1 | One-cycle end-of-read pulse |
| cs_n | output | 1 | Flash chip select, active low |
| sclk | output | 1 | Serial clock to the flash |
| io_out | output | 4 | Data value driven onto the four wires |
| io_oe | output | 4 | Per-wire output enable |
| io_in | input | 4 | Data sampled from the four wires |

## Verification
The bench sweeps all four parameter codes against several byte counts and against addresses that include all-zero, near-top and mixed-bit patterns. A flash model checks the opcode and address nibbles and counts the rising edges, so a dummy decode that treats code 01 as six clocks, or that swaps codes 10 and 11, shows up as a wrong edge count and as corrupted bytes. The model also checks the output enable on every edge: releasing the wires one clock early or late is caught, as is a nibble order reversed inside a byte. A parameter write and a stray request made in the middle of a read check that the controller holds the values it captured when the read began. The bench measures the high and low times of the serial clock and checks that the end pulse follows chip select.

// File: rtl/qfr_pkg.sv
package qfr_pkg;

  localparam logic [7:0] QFR_OPCODE = 8'h0B;
  localparam int         QFR_HDR_CLKS = 8;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_HOLD,
    ST_FIN
  } qfr_state_t;

  function automatic logic [3:0] dummy_clocks(input logic [1:0] field);
    case (field)
      2'b10:   dummy_clocks = 4'd6;
      2'b11:   dummy_clocks = 4'd8;
      default: dummy_clocks = 4'd4;
    endcase
  endfunction

endpackage

// File: rtl/qfr_cfg.sv
module qfr_cfg (
  input  logic       clk,
  input  logic       rst,
  input  logic       we,
  input  logic [1:0] wdata,
  output logic [1:0] field
);
  always_ff @(posedge clk) begin
    if (rst) field <= 2'b00;
    else if (we) field <= wdata;
  end
endmodule

// File: rtl/qfr_clkgen.sv
module qfr_clkgen #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic rise_tick,
  output logic fall_tick,
  output logic sclk
);
  localparam int HALF = DIV / 2;
  localparam int CW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt;

  assign rise_tick = en && (cnt == CW'(HALF - 1));
  assign fall_tick = en && (cnt == CW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + CW'(1);
      if (rise_tick)      sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/qfr_rxpack.sv
module qfr_rxpack (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       sample,
  input  logic [3:0] nib,
  output logic       byte_valid,
  output logic [7:0] byte_data
);
  logic       second;
  logic [3:0] hi;

  always_ff @(posedge clk) begin
    if (rst) begin
      second     <= 1'b0;
      hi         <= 4'h0;
      byte_valid <= 1'b0;
      byte_data  <= 8'h00;
    end else begin
      byte_valid <= 1'b0;
      if (clear) begin
        second <= 1'b0;
      end else if (sample) begin
        if (!second) begin
          hi     <= nib;
          second <= 1'b1;
        end else begin
          byte_data  <= {hi, nib};
          byte_valid <= 1'b1;
          second     <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/qfr_ctrl.sv
module qfr_ctrl
  import qfr_pkg::*;
#(
  parameter int DIV   = 4,
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_field,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [23:0]      req_addr,
  input  logic [CNT_W-1:0] req_len,
  output logic             rd_valid,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             cs_n,
  output logic             sclk,
  output logic [3:0]       io_out,
  output logic [3:0]       io_oe,
  input  logic [3:0]       io_in
);
  localparam int IDX_W = CNT_W + 6;

  qfr_state_t       state;
  logic             run;
  logic             rise_tick, fall_tick;
  logic [1:0]       field;
  logic [IDX_W-1:0] clk_idx, data_start, last_idx;
  logic [27:0]      sh;
  logic             accept, sample;
  logic [3:0]       dcnt;

  qfr_cfg u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we), .wdata(cfg_field), .field(field)
  );

  qfr_clkgen #(.DIV(DIV)) u_clk (
    .clk(clk), .rst(rst), .en(run),
    .rise_tick(rise_tick), .fall_tick(fall_tick), .sclk(sclk)
  );

  assign req_ready = (state == ST_IDLE);
  assign accept    = req_ready && req_valid;
  assign dcnt      = dummy_clocks(field);
  assign sample    = (state == ST_RUN) && rise_tick && (clk_idx >= data_start);

  qfr_rxpack u_rx (
    .clk(clk), .rst(rst), .clear(accept), .sample(sample), .nib(io_in),
    .byte_valid(rd_valid), .byte_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      run        <= 1'b0;
      cs_n       <= 1'b1;
      io_out     <= 4'h0;
      io_oe      <= 4'h0;
      done       <= 1'b0;
      clk_idx    <= '0;
      data_start <= '0;
      last_idx   <= '0;
      sh         <= '0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (accept) begin
            state      <= ST_RUN;
            run        <= 1'b1;
            cs_n       <= 1'b0;
            io_oe      <= 4'hF;
            io_out     <= QFR_OPCODE[7:4];
            sh         <= {QFR_OPCODE[3:0], req_addr};
            clk_idx    <= '0;
            data_start <= IDX_W'(QFR_HDR_CLKS) + IDX_W'(dcnt);
            last_idx   <= IDX_W'(QFR_HDR_CLKS + 1) + IDX_W'(dcnt)
                          + (IDX_W'(req_len) << 1);
          end
        end
        ST_RUN: begin
          if (fall_tick) begin
            clk_idx <= clk_idx + IDX_W'(1);
            if (clk_idx < IDX_W'(QFR_HDR_CLKS - 1)) begin
              io_out <= sh[27:24];
              sh     <= {sh[23:0], 4'h0};
            end else begin
              io_out <= 4'h0;
            end
            if (clk_idx == data_start - IDX_W'(1)) io_oe <= 4'h0;
            if (clk_idx == last_idx) begin
              run   <= 1'b0;
              state <= ST_HOLD;
            end
          end
        end
        ST_HOLD: begin
          cs_n  <= 1'b1;
          state <= ST_FIN;
        end
        default: begin
          done  <= 1'b1;
          state <= ST_IDLE;
        end
      endcase
    end
  end
endmodule

// File: rtl/qfr_ctrl_chk.sv
module qfr_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic       req_ready,
  input logic       rd_valid,
  input logic       done,
  input logic       cs_n,
  input logic       sclk,
  input logic [3:0] io_out,
  input logic [3:0] io_oe
);
  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (rst) cs_n |-> !sclk); // R7
  AST_OUT_STABLE_HIGH: assert property (@(posedge clk) disable iff (rst) sclk |-> $stable(io_out)); // R2
  AST_OE_RELEASED_IDLE: assert property (@(posedge clk) disable iff (rst) cs_n |-> (io_oe == 4'h0)); // R5
  AST_OE_ALL_OR_NONE: assert property (@(posedge clk) disable iff (rst) (io_oe == 4'h0) || (io_oe == 4'hF)); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) rd_valid |=> !rd_valid); // R6
  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (rst) rd_valid |-> !cs_n); // R6
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R8
  AST_DONE_FOLLOWS_CS: assert property (@(posedge clk) disable iff (rst) $rose(cs_n) |=> done); // R8
  AST_DONE_READY: assert property (@(posedge clk) disable iff (rst) done |-> (req_ready && cs_n)); // R8
endmodule

bind qfr_ctrl qfr_ctrl_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .rd_valid(rd_valid),
  .done(done), .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe)
);

// File: tb/qfr_ctrl_test.sv
`timescale 1ns/1ps
module qfr_ctrl_test;
  localparam int DIV   = 4;
  localparam int CNT_W = 4;
  localparam int HALF  = DIV / 2;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             cfg_we = 1'b0;
  logic [1:0]       cfg_field = 2'b00;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [23:0]      req_addr = '0;
  logic [CNT_W-1:0] req_len = '0;
  logic             rd_valid;
  logic [7:0]       rd_data;
  logic             done;
  logic             cs_n, sclk;
  logic [3:0]       io_out, io_oe;
  logic [3:0]       io_in = 4'h0;

  always #5 clk = ~clk;

  qfr_ctrl #(.DIV(DIV), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_field(cfg_field),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_len(req_len), .rd_valid(rd_valid), .rd_data(rd_data), .done(done),
    .cs_n(cs_n), .sclk(sclk), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
  );

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] fdata(input logic [23:0] a);
    fdata = {a[4:0], a[7:5]} ^ a[15:8] ^ a[23:16] ^ 8'h3C;
  endfunction

  // flash model state
  int          rises, exp_d, got, oe_err, cs_err, tim_err, done_cnt, done_cs_err;
  int          hi_run, lo_run;
  logic        prev_sclk;
  logic [31:0] cap;
  logic [23:0] cur_addr;

  always @(negedge cs_n) rises = 0;

  always @(posedge sclk) begin
    if (cs_n) cs_err++;
    if (rises < 8) begin
      cap = {cap[27:0], io_out};
      if (io_oe != 4'hF) oe_err++;
    end else if (rises < 8 + exp_d) begin
      if (io_oe != 4'hF) oe_err++;
    end else if (io_oe != 4'h0) begin
      oe_err++;
    end
    rises++;
  end

  always @(negedge sclk) begin
    if (!cs_n && rises >= 8 + exp_d) begin
      automatic int k = rises - 8 - exp_d;
      automatic logic [7:0] b = fdata(cur_addr + 24'(k / 2));
      io_in = (k % 2 == 0) ? b[7:4] : b[3:0];
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      if (rd_valid) begin
        chk($sformatf("R6 byte %0d at %06h", got, cur_addr), {24'h0, rd_data},
            {24'h0, fdata(cur_addr + 24'(got))});
        got++;
      end
      if (done) begin
        done_cnt++;
        if (!cs_n || !req_ready) done_cs_err++;
      end
      if (sclk) begin
        if (!prev_sclk && lo_run != HALF) tim_err++;
        hi_run++;
        lo_run = 0;
      end else begin
        if (prev_sclk && hi_run != HALF) tim_err++;
        hi_run = 0;
        if (!cs_n) lo_run++;
        else lo_run = 0;
      end
      prev_sclk = sclk;
    end
  end

  function automatic int dec(input logic [1:0] f);
    dec = (f == 2'b11) ? 8 : (f == 2'b10) ? 6 : 4;
  endfunction

  task automatic write_cfg(input logic [1:0] f);
    @(negedge clk);
    cfg_we = 1'b1;
    cfg_field = f;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // poke: during the read, write new_f and raise a stray request
  task automatic do_read(input logic [23:0] a, input logic [CNT_W-1:0] len,
                         input int d, input bit poke, input logic [1:0] new_f);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    cur_addr = a; exp_d = d; got = 0; oe_err = 0; cs_err = 0;
    tim_err = 0; done_cnt = 0; done_cs_err = 0; cap = '0;
    req_valid = 1'b1; req_addr = a; req_len = len;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      repeat (10) @(negedge clk);
      cfg_we = 1'b1; cfg_field = new_f;
      req_valid = 1'b1; req_addr = ~a; req_len = ~len;
      @(negedge clk);
      cfg_we = 1'b0;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    while (done_cnt == 0) @(negedge clk);
    repeat (3) @(negedge clk);
    chk("R2 opcode", {24'h0, cap[31:24]}, 32'h0B);
    chk("R3 address", {8'h0, cap[23:0]}, {8'h0, a});
    chk("R4 R7 rising edges", rises, 8 + d + 2 * (int'(len) + 1));
    chk("R6 byte count", got, int'(len) + 1);
    chk("R5 output enable", oe_err, 0);
    chk("R7 cs framing", cs_err, 0);
    chk("R9 sclk timing", tim_err, 0);
    chk("R8 done pulse", done_cnt, 1);
    chk("R8 done with cs high", done_cs_err, 0);
    if (poke) chk("R10 idle after stray request", {31'h0, req_ready}, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    logic [23:0] addrs [3];
    addrs[0] = 24'h000000; addrs[1] = 24'hFFFFFE; addrs[2] = 24'h5A3C81;
    prev_sclk = 1'b0; hi_run = 0; lo_run = 0; rises = 0; exp_d = 4;
    repeat (3) @(negedge clk);
    chk("R1 cs_n in reset", {31'h0, cs_n}, 1);
    chk("R1 sclk in reset", {31'h0, sclk}, 0);
    chk("R1 oe in reset", {28'h0, io_oe}, 0);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    chk("R1 cs_n idle", {31'h0, cs_n}, 1);
    chk("R1 sclk idle", {31'h0, sclk}, 0);
    chk("R1 oe idle", {28'h0, io_oe}, 0);
    chk("R1 ready idle", {31'h0, req_ready}, 1);
    chk("R1 no strobes", {30'h0, rd_valid, done}, 0);

    for (int f = 0; f < 4; f++) begin
      write_cfg(2'(f));
      for (int ai = 0; ai < 3; ai++)
        for (int l = 0; l < 4; l++)
          do_read(addrs[ai], CNT_W'(l), dec(2'(f)), 1'b0, 2'b00);
    end

    write_cfg(2'b10);
    do_read(24'h123456, CNT_W'(15), 6, 1'b0, 2'b00);

    // R4 write during a read applies only to the next read; R10 stray request ignored
    write_cfg(2'b11);
    do_read(24'hABCDEF, CNT_W'(2), 8, 1'b1, 2'b00);
    do_read(24'h00F00F, CNT_W'(1), 4, 1'b0, 2'b00);
    do_read(24'h800001, CNT_W'(0), 4, 1'b1, 2'b10);
    do_read(24'h7FFFFF, CNT_W'(3), 6, 1'b0, 2'b00);

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule